// File: doc/BRIEF.md
# Latched Level-Two Interrupt Aggregator

The block gathers up to 32 peripheral interrupt lines into a single summary request for a parent interrupt controller. Each line has one bit position in every register. Each line first passes through a synchroniser. In the default latched build, a rising edge on a synchronised line sets a sticky pending bit. That bit stays set until software writes a one to it through the clear register. A build parameter selects a level variant instead. In the level variant the pending bit simply tracks the synchronised line, there is no clear register, and the mask registers move down to lower offsets.

Masking never needs a read-modify-write. Software writes ones to one register to disable lines and ones to another register to enable them. A third, read-only register returns the resulting mask, where a one means the line is disabled. The summary output is high whenever some pending bit has its mask bit at zero. Software reaches the registers over a simple 32-bit bus. Writes take effect on the clock edge where select and write-enable are both high. Read data is combinational from the address while select is high and write-enable is low, and is zero otherwise.

Top module: `lvl2_irq_agg`

## Requirements
- R1: After reset every mask bit reads one (all lines disabled), every pending bit reads zero and irq_o is low.
- R2: In the latched build, a rising edge on src_i sets the matching pending bit. The bit reads as one from the third clock edge after the input change. It stays one after the input falls.
- R3: In the latched build, a write to offset 0x08 clears every pending bit whose data bit is one. Pending bits written as zero keep their value.
- R4: A write to the mask-set offset sets the mask bits written as one, and a write to the mask-unmask offset clears the mask bits written as one. Zero data bits leave the mask alone. The mask reads back at the mask-status offset. Latched offsets are mask-status 0x0C, mask-set 0x10 and mask-unmask 0x14.
- R5: irq_o is one exactly when some bit of (pending AND NOT mask) is one. It follows register state with no added delay.
- R6: A pending bit latches while its line is masked. Unmasking the line later raises irq_o.
- R7: When a new rising edge on a line and a clear write to that same bit fall on the same clock edge, the bit ends up pending.
- R8: In the level build, the pending bit equals the input, delayed by the same three clock edges, and falls when the input falls. The level offsets are status 0x00, mask-status 0x04, mask-set 0x08 and mask-unmask 0x0C, so 0x08 acts as mask-set and not as a clear.
- R9: Reads of unmapped offsets, and of the write-only offsets, return zero. Writes to the status offset, the mask-status offset or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source lines, one per bit |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when no read is selected |
| irq_o | output | 1 | Summary interrupt to the parent controller |

## Verification
Some rules are checked by the assertions on every cycle:
- a set in the same cycle as a clear leaves the bit pending;
- pending bits stay sticky unless cleared, and a clear takes effect;
- level status follows the synchroniser output;
- mask bits move only on set or unmask writes;
- writes to read-only or unmapped offsets produce no update pulse.

Other behaviour needs the bench scenarios, because it spans the whole path from pins to pins. This covers the three-edge latency from a pin to a readable status bit, an event that latches while masked and is exposed later, the shifted level register map, and the read values of unmapped offsets. The bench checks these against its running model of both builds.

// File: rtl/lvl2_irq_pkg.sv
package lvl2_irq_pkg;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_STATUS,
        RSEL_CLEAR,
        RSEL_MSTAT,
        RSEL_MSET,
        RSEL_MCLR
    } rsel_e;

    // Latched build offsets
    localparam logic [7:0] LAT_STATUS = 8'h00;
    localparam logic [7:0] LAT_CLEAR  = 8'h08;
    localparam logic [7:0] LAT_MSTAT  = 8'h0C;
    localparam logic [7:0] LAT_MSET   = 8'h10;
    localparam logic [7:0] LAT_MCLR   = 8'h14;

    // Level build offsets (no clear register)
    localparam logic [7:0] LVL_STATUS = 8'h00;
    localparam logic [7:0] LVL_MSTAT  = 8'h04;
    localparam logic [7:0] LVL_MSET   = 8'h08;
    localparam logic [7:0] LVL_MCLR   = 8'h0C;

    function automatic rsel_e decode_offset(input logic [15:0] off, input logic latched);
        rsel_e r;
        r = RSEL_NONE;
        if (off[15:8] == 8'h00) begin
            if (latched) begin
                case (off[7:0])
                    LAT_STATUS: r = RSEL_STATUS;
                    LAT_CLEAR:  r = RSEL_CLEAR;
                    LAT_MSTAT:  r = RSEL_MSTAT;
                    LAT_MSET:   r = RSEL_MSET;
                    LAT_MCLR:   r = RSEL_MCLR;
                    default:    r = RSEL_NONE;
                endcase
            end else begin
                case (off[7:0])
                    LVL_STATUS: r = RSEL_STATUS;
                    LVL_MSTAT:  r = RSEL_MSTAT;
                    LVL_MSET:   r = RSEL_MSET;
                    LVL_MCLR:   r = RSEL_MCLR;
                    default:    r = RSEL_NONE;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lvl2_irq_sync.sv
module lvl2_irq_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din_i,
    output logic [N-1:0] dout_o
);

    logic [STAGES-1:0][N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout_o = chain_q[STAGES-1];

endmodule

// File: rtl/lvl2_irq_status.sv
module lvl2_irq_status #(
    parameter int N       = 32,
    parameter int LATCHED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);

    generate
        if (LATCHED != 0) begin : g_latch
            typedef struct packed {
                logic [N-1:0] prev;
                logic [N-1:0] stat;
            } lat_st_t;

            lat_st_t      st_d, st_q;
            logic [N-1:0] rise;

            always_comb begin
                rise       = sync_i & ~st_q.prev;
                st_d.prev  = sync_i;
                // a fresh edge overrides a clear in the same cycle
                st_d.stat  = (st_q.stat & ~clr_i) | rise;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign status_o = st_q.stat;

            a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (|(rise & clr_i)) |=>
                ((st_q.stat & $past(rise & clr_i)) == $past(rise & clr_i)));

            a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (|(st_q.stat & ~clr_i)) |=>
                ((st_q.stat & $past(st_q.stat & ~clr_i)) == $past(st_q.stat & ~clr_i)));

            a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                (|(clr_i & ~rise)) |=>
                ((st_q.stat & $past(clr_i & ~rise)) == '0));
        end else begin : g_level
            logic [N-1:0] stat_d, stat_q;
            logic         unused_clr_bits;

            assign unused_clr_bits = ^clr_i;

            always_comb begin
                stat_d = sync_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stat_q <= '0;
                end else begin
                    stat_q <= stat_d;
                end
            end

            assign status_o = stat_q;

            a_r8_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (stat_q == $past(sync_i)));
        end
    endgenerate

endmodule

// File: rtl/lvl2_irq_mask.sv
module lvl2_irq_mask #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] mask_o
);

    typedef struct packed {
        logic [N-1:0] mask;
    } mask_st_t;

    mask_st_t mk_d, mk_q;

    always_comb begin
        mk_d.mask = (mk_q.mask | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk_q.mask <= '1;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign mask_o = mk_q.mask;

    a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((mk_q.mask & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

    a_r4_unmask_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((mk_q.mask & $past(clr_i)) == '0));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(mk_q.mask));

endmodule

// File: rtl/lvl2_irq_regif.sv
module lvl2_irq_regif
    import lvl2_irq_pkg::*;
#(
    parameter int N       = 32,
    parameter int ADDR_W  = 8,
    parameter int LATCHED = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [N-1:0]      status_i,
    input  logic [N-1:0]      mask_i,
    output logic [N-1:0]      clr_o,
    output logic [N-1:0]      mset_o,
    output logic [N-1:0]      mclr_o,
    output logic [31:0]       rdata_o
);

    rsel_e rs;
    logic  wr;
    logic  rd;

    always_comb begin
        rs      = decode_offset(16'(addr_i), (LATCHED != 0));
        wr      = sel_i && we_i;
        rd      = sel_i && !we_i;
        clr_o   = (wr && rs == RSEL_CLEAR) ? wdata_i[N-1:0] : '0;
        mset_o  = (wr && rs == RSEL_MSET)  ? wdata_i[N-1:0] : '0;
        mclr_o  = (wr && rs == RSEL_MCLR)  ? wdata_i[N-1:0] : '0;
        rdata_o = '0;
        if (rd) begin
            case (rs)
                RSEL_STATUS: rdata_o = 32'(status_i);
                RSEL_MSTAT:  rdata_o = 32'(mask_i);
                default:     rdata_o = '0;
            endcase
        end
    end

    a_r9_ro_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && we_i && (rs == RSEL_STATUS || rs == RSEL_MSTAT || rs == RSEL_NONE))
        |-> (clr_o == '0 && mset_o == '0 && mclr_o == '0));

    a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i) |-> (rdata_o == '0));

endmodule

// File: rtl/lvl2_irq_agg.sv
module lvl2_irq_agg
    import lvl2_irq_pkg::*;
#(
    parameter int NSRC        = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LATCHED     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);

    logic [NSRC-1:0] sync_w;
    logic [NSRC-1:0] status_w;
    logic [NSRC-1:0] mask_w;
    logic [NSRC-1:0] clr_w;
    logic [NSRC-1:0] mset_w;
    logic [NSRC-1:0] mclr_w;

    lvl2_irq_sync #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (src_i),
        .dout_o (sync_w)
    );

    lvl2_irq_status #(.N(NSRC), .LATCHED(LATCHED)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_w),
        .clr_i    (clr_w),
        .status_o (status_w)
    );

    lvl2_irq_mask #(.N(NSRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (mset_w),
        .clr_i  (mclr_w),
        .mask_o (mask_w)
    );

    lvl2_irq_regif #(.N(NSRC), .ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel_i),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (status_w),
        .mask_i   (mask_w),
        .clr_o    (clr_w),
        .mset_o   (mset_w),
        .mclr_o   (mclr_w),
        .rdata_o  (bus_rdata_o)
    );

    assign irq_o = |(status_w & ~mask_w);

    a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (|status_w));

endmodule

// File: tb/lvl2_irq_agg_bench.sv
`timescale 1ns/1ps
module lvl2_irq_agg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel   [2];
    logic        we    [2];
    logic [7:0]  addr  [2];
    logic [31:0] wdata [2];
    logic [31:0] rdata [2];
    logic        irq   [2];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    lvl2_irq_agg #(.LATCHED(1)) u_lvl2_irq_agg (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel_i(sel[0]), .bus_we_i(we[0]), .bus_addr_i(addr[0]),
        .bus_wdata_i(wdata[0]), .bus_rdata_o(rdata[0]), .irq_o(irq[0]));

    lvl2_irq_agg #(.LATCHED(0)) u_lvl2_irq_agg_lvl (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel_i(sel[1]), .bus_we_i(we[1]), .bus_addr_i(addr[1]),
        .bus_wdata_i(wdata[1]), .bus_rdata_o(rdata[1]), .irq_o(irq[1]));

    // behavioural reference: index 0 latched build, index 1 level build
    logic [31:0] m_s1 [2], m_s2 [2], m_prev [2], m_stat [2], m_mask [2];

    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                m_s1[m] = '0; m_s2[m] = '0; m_prev[m] = '0;
                m_stat[m] = '0; m_mask[m] = '1;
            end else begin
                logic [31:0] clrb, msetb, mclrb;
                bit lat;
                bit wv;
                lat   = (m == 0);
                wv    = sel[m] && we[m];
                clrb  = (wv && lat && addr[m] == 8'h08) ? wdata[m] : '0;
                msetb = (wv && addr[m] == (lat ? 8'h10 : 8'h08)) ? wdata[m] : '0;
                mclrb = (wv && addr[m] == (lat ? 8'h14 : 8'h0C)) ? wdata[m] : '0;
                m_stat[m] = lat ? ((m_stat[m] & ~clrb) | (m_s2[m] & ~m_prev[m])) : m_s2[m];
                m_prev[m] = m_s2[m];
                m_s2[m]   = m_s1[m];
                m_s1[m]   = src;
                m_mask[m] = (m_mask[m] | msetb) & ~mclrb;
            end
        end
    end

    function automatic logic [31:0] mread(int m, logic [7:0] a);
        if (a == 8'h00) return m_stat[m];
        if (m == 0 && a == 8'h0C) return m_mask[m];
        if (m == 1 && a == 8'h04) return m_mask[m];
        return '0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R5 compared against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int m = 0; m < 2; m++) begin
                chk("R5 irq vs model", 32'(irq[m]), 32'(|(m_stat[m] & ~m_mask[m])));
            end
        end
    end

    task automatic wr(int m, logic [7:0] a, logic [31:0] d);
        sel[m] = 1'b1; we[m] = 1'b1; addr[m] = a; wdata[m] = d;
        @(negedge clk);
        sel[m] = 1'b0; we[m] = 1'b0;
    endtask

    task automatic rd(int m, logic [7:0] a, logic [31:0] exp, string req);
        sel[m] = 1'b1; we[m] = 1'b0; addr[m] = a;
        #2;
        chk(req, rdata[m], exp);
        @(negedge clk);
        sel[m] = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(1_500_000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            sel[m] = 1'b0; we[m] = 1'b0; addr[m] = '0; wdata[m] = '0;
        end
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(0, 8'h0C, 32'hFFFF_FFFF, "R1 latched mask");
        rd(0, 8'h00, 32'h0, "R1 latched status");
        rd(1, 8'h04, 32'hFFFF_FFFF, "R1 level mask");
        rd(1, 8'h00, 32'h0, "R1 level status");
        chk("R1 irq latched", 32'(irq[0]), 32'h0);
        chk("R1 irq level", 32'(irq[1]), 32'h0);

        // R2 edge latch and stickiness, R8 level follow
        src = 32'h5;
        idle(3);
        rd(0, 8'h00, 32'h5, "R2 latched after three edges");
        rd(1, 8'h00, 32'h5, "R8 level high");
        src = 32'h0;
        idle(3);
        rd(0, 8'h00, 32'h5, "R2 sticky after input falls");
        rd(1, 8'h00, 32'h0, "R8 level drops");
        chk("R5 masked pending no irq", 32'(irq[0]), 32'h0);

        // R4 unmask, R5 irq
        wr(0, 8'h14, 32'h1);
        rd(0, 8'h0C, 32'hFFFF_FFFE, "R4 unmask bit0");
        chk("R5 irq on unmasked pending", 32'(irq[0]), 32'h1);

        // R3 clear only ones
        wr(0, 8'h08, 32'h1);
        rd(0, 8'h00, 32'h4, "R3 clear bit0 keep bit2");
        chk("R3 irq drops", 32'(irq[0]), 32'h0);

        // R6 latched while masked, exposed by unmask
        wr(0, 8'h14, 32'h4);
        rd(0, 8'h0C, 32'hFFFF_FFFA, "R4 unmask bit2");
        chk("R6 masked event exposed", 32'(irq[0]), 32'h1);
        wr(0, 8'h10, 32'h4);
        rd(0, 8'h0C, 32'hFFFF_FFFE, "R4 mask set bit2");
        chk("R4 irq after re-mask", 32'(irq[0]), 32'h0);

        // R9 ignored writes and zero reads
        wr(0, 8'h00, 32'hFFFF_FFFF);
        rd(0, 8'h00, 32'h4, "R9 status write ignored");
        wr(0, 8'h04, 32'h0);
        wr(0, 8'h0C, 32'h0);
        rd(0, 8'h0C, 32'hFFFF_FFFE, "R9 mask status write ignored");
        rd(0, 8'h04, 32'h0, "R9 unmapped 0x04");
        rd(0, 8'h08, 32'h0, "R9 clear reads zero");
        rd(0, 8'h10, 32'h0, "R9 mask set reads zero");
        rd(0, 8'hF0, 32'h0, "R9 unmapped 0xF0");

        // R7 edge and clear on the same clock edge
        src = 32'h4;
        idle(2);
        wr(0, 8'h08, 32'h4);
        rd(0, 8'h00, 32'h4, "R7 set wins over clear");
        src = 32'h0;
        wr(0, 8'h08, 32'h4);
        rd(0, 8'h00, 32'h0, "R3 clear without edge");

        // R8 level build map and behaviour
        src = 32'h8;
        idle(3);
        rd(1, 8'h00, 32'h8, "R8 level status");
        wr(1, 8'h0C, 32'h8);
        rd(1, 8'h04, 32'hFFFF_FFF7, "R8 level unmask at 0x0C");
        chk("R8 level irq high", 32'(irq[1]), 32'h1);
        src = 32'h0;
        idle(3);
        rd(1, 8'h00, 32'h0, "R8 level status drops");
        chk("R8 level irq drops", 32'(irq[1]), 32'h0);
        src = 32'h8;
        idle(3);
        chk("R8 level irq reasserts", 32'(irq[1]), 32'h1);
        wr(1, 8'h08, 32'h8);
        rd(1, 8'h04, 32'hFFFF_FFFF, "R8 0x08 is mask set");
        chk("R8 irq after mask set", 32'(irq[1]), 32'h0);
        rd(1, 8'h14, 32'h0, "R9 level unmapped 0x14");
        src = 32'h0;
        idle(3);

        // randomised traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int m;
            int op;
            logic [7:0] a;
            m  = int'($urandom_range(0, 1));
            op = int'($urandom_range(0, 5));
            src = src ^ ($urandom & $urandom & $urandom);
            case ($urandom_range(0, 7))
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h08;
                3: a = 8'h0C;
                4: a = 8'h10;
                5: a = 8'h14;
                6: a = 8'h18;
                default: a = 8'(($urandom_range(0, 63)) << 2);
            endcase
            if (op < 2) begin
                wr(m, a, $urandom);
            end else if (op < 4) begin
                rd(m, a, mread(m, a), "R9 read vs model");
            end else begin
                idle(1);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule